// File: doc/BRIEF.md
# 8-bit PWM timer with compare output

This block is an 8-bit counter that steps once per cycle in which its tick enable is high. A 3-bit waveform code picks how it counts and where its ceiling (TOP) lies. It can wrap freely at the all-ones value, restart after matching compare register A, run as a single-slope PWM, or run as a dual-slope PWM that counts up and then back down. A second compare register, B, is matched against the count. Each match, and each arrival at TOP, can set or clear one waveform output pin according to a 2-bit output-action field.

The block is used through a small register write/read port. The compare registers are double-buffered. When a written value takes effect depends on the waveform code: at once in the simple counting codes, and at a period boundary in the PWM codes, so that a PWM period never runs with a mixed setting. A sticky overflow flag marks the mode-dependent period point. Software clears it by writing a one to it.

All actions happen at the clock edge of a tick cycle. They are decided by the count held before that edge.

Top module: `pwm8_timer`

## Requirements
- R1: After synchronous reset the count is 0, the overflow flag is 0, every register reads 0, the internal pin state is 0, and `pwm_out` follows `gpio_in`.
- R2: The count changes only at the edge of a cycle with `tick` high. A write to address 3 loads `wr_data` into the count, and the tick of that same cycle then has no effect.
- R3: Waveform code (register 0 bits 2:0) selects the counting sequence. Codes 0, 4 and 6 (normal) count up and wrap from 0xFF to 0. Code 2 (restart) and code 7 (single-slope, ceiling A) go to 0 on the tick taken at TOP = effective compare A. Code 3 (single-slope) wraps at TOP = 0xFF. Codes 1 (TOP 0xFF) and 5 (TOP = compare A) count up to TOP and then down to 0, turning at each end without repeating a value.
- R4: In codes 0, 2, 4 and 6 a compare write is effective from the next cycle. In codes 1, 3, 5 and 7 the written value becomes effective at the tick taken while the count is at TOP.
- R5: The overflow flag is set by the tick taken at count 0xFF in codes 0, 2, 3, 4 and 6, at count 0 in codes 1 and 5, and at TOP in code 7.
- R6: The overflow flag (register 4 bit 0) stays set until a write of 1 to that bit. If a set event and a clearing write fall in the same cycle, the flag ends set.
- R7: With output-action field (register 0 bits 5:4) equal to 00 or 01, `pwm_out` equals `gpio_in`, and the pin state does not change.
- R8: In codes 3 and 7, action 10 sets the pin at TOP and clears it on a B match. Action 11 clears it at TOP and sets it on a B match. The TOP action wins.
- R9: In codes 1 and 5, action 10 clears the pin on a B match at an upward step and sets it on a B match at a downward step. Action 11 does the reverse. A step is upward if the count rises, or if it turns at 0.
- R10: When effective compare B equals TOP and the action field's upper bit is set, B matches are ignored. In the PWM codes the TOP action still applies: set for 10, clear for 11.
- R11: In codes 0, 2, 4 and 6, action 10 clears the pin on a B match and action 11 sets it.
- R12: Register map: 0 = control (bits 2:0 waveform, bits 5:4 action, other bits read 0), 1 = compare A buffer, 2 = compare B buffer, 3 = count, 4 = flag in bit 0 with other bits reading 0. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| gpio_in | input | 1 | Value driven on the pin when the action field is disconnected |
| pwm_out | output | 1 | Waveform output pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| count_out | output | 8 | Current count |

## Verification
Two pairs of functions can fall in the same cycle. The first is an overflow event and a software write that clears the flag. The second is a tick and a write that loads the count. The bench places a flag-clearing write on the exact tick at which the count sits at 0xFF, then checks that the flag reads set and that the count still wrapped to 0. It also pairs a count write with a tick and checks that the written value wins with no extra step. Random traffic repeats both collisions across every waveform code, and each cycle is judged against a bench model.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPB  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd4;

    typedef enum logic [1:0] {
        WK_NORMAL = 2'd0,
        WK_CTC    = 2'd1,
        WK_FAST   = 2'd2,
        WK_PHASE  = 2'd3
    } wave_kind_e;

    typedef struct packed {
        wave_kind_e kind;
        logic       top_from_a;
    } wave_cfg_t;

    // Reserved codes fall back to plain up-counting.
    function automatic wave_cfg_t decode_mode(input logic [2:0] code);
        wave_cfg_t c;
        c.kind       = WK_NORMAL;
        c.top_from_a = 1'b0;
        case (code)
            3'd1: begin c.kind = WK_PHASE; c.top_from_a = 1'b0; end
            3'd2: begin c.kind = WK_CTC;   c.top_from_a = 1'b1; end
            3'd3: begin c.kind = WK_FAST;  c.top_from_a = 1'b0; end
            3'd5: begin c.kind = WK_PHASE; c.top_from_a = 1'b1; end
            3'd7: begin c.kind = WK_FAST;  c.top_from_a = 1'b1; end
            default: begin c.kind = WK_NORMAL; c.top_from_a = 1'b0; end
        endcase
        return c;
    endfunction

    function automatic logic is_immediate(input wave_kind_e k);
        return (k == WK_NORMAL) || (k == WK_CTC);
    endfunction

endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      cnt,
    input  logic              immediate,
    input  logic              load_evt,
    input  logic              ovf_evt,
    output logic [2:0]        mode,
    output logic [1:0]        com,
    output logic [W-1:0]      eff_a,
    output logic [W-1:0]      eff_b,
    output logic              ovf_flag,
    output logic [W-1:0]      rd_data
);

    logic [W-1:0] buf_a, buf_b;
    logic [W-1:0] buf_a_nx, buf_b_nx;
    logic         wr_ctrl, wr_flag_clr;

    assign wr_ctrl     = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_flag_clr = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

    always_comb begin
        buf_a_nx = buf_a;
        buf_b_nx = buf_b;
        if (wr_en && (wr_addr == ADDR_CMPA)) buf_a_nx = wr_data;
        if (wr_en && (wr_addr == ADDR_CMPB)) buf_b_nx = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            com      <= '0;
            buf_a    <= '0;
            buf_b    <= '0;
            eff_a    <= '0;
            eff_b    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode <= wr_data[2:0];
                com  <= wr_data[5:4];
            end
            buf_a <= buf_a_nx;
            buf_b <= buf_b_nx;
            if (immediate) begin
                eff_a <= buf_a_nx;
                eff_b <= buf_b_nx;
            end else if (load_evt) begin
                eff_a <= buf_a;
                eff_b <= buf_b;
            end
            if (ovf_evt)          ovf_flag <= 1'b1;
            else if (wr_flag_clr) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[2:0] = mode;
                rd_data[5:4] = com;
            end
            ADDR_CMPA:  rd_data = buf_a;
            ADDR_CMPB:  rd_data = buf_b;
            ADDR_COUNT: rd_data = cnt;
            ADDR_FLAG:  rd_data[0] = ovf_flag;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       load,
    input  logic [W-1:0] load_val,
    input  wave_kind_e kind,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic       adv,
    output logic       at_top,
    output logic       step_up,
    output logic       ovf_evt
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic         dir_up;
    logic [W-1:0] nxt_cnt;
    logic         nxt_up;
    logic         ovf_hit;

    assign adv = tick && !load;

    always_comb begin
        if (kind == WK_PHASE) at_top = dir_up && (cnt >= top);
        else                  at_top = (cnt == top);
        step_up = dir_up ? !at_top : (cnt == '0);
    end

    always_comb begin
        nxt_cnt = cnt;
        nxt_up  = dir_up;
        if (kind == WK_PHASE) begin
            if (dir_up) begin
                if (at_top) begin
                    nxt_cnt = (cnt == '0) ? '0 : cnt - ONE;
                    nxt_up  = 1'b0;
                end else begin
                    nxt_cnt = cnt + ONE;
                end
            end else begin
                if (cnt == '0) begin
                    nxt_cnt = (top == '0) ? '0 : ONE;
                    nxt_up  = 1'b1;
                end else begin
                    nxt_cnt = cnt - ONE;
                end
            end
        end else begin
            nxt_cnt = at_top ? '0 : cnt + ONE;
            nxt_up  = 1'b1;
        end
    end

    always_comb begin
        case (kind)
            WK_PHASE: ovf_hit = (cnt == '0);
            WK_FAST:  ovf_hit = (cnt == top);
            default:  ovf_hit = (cnt == MAXV);
        endcase
    end

    assign ovf_evt = adv && ovf_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else begin
            if (load) begin
                cnt <= load_val;
            end else if (adv) begin
                cnt    <= nxt_cnt;
                dir_up <= nxt_up;
            end
            if (kind != WK_PHASE) dir_up <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  wave_kind_e   kind,
    input  logic [1:0]   com,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    input  logic         at_top,
    input  logic         step_up,
    output logic         pin_q
);

    logic special, hit, non_inv, pin_nx;

    always_comb begin
        special = com[1] && (cmp == top);
        hit     = (cnt == cmp) && !special;
        non_inv = (com == 2'b10);
        pin_nx  = pin_q;
        if (com[1]) begin
            case (kind)
                WK_FAST: begin
                    if (at_top)   pin_nx = non_inv;
                    else if (hit) pin_nx = !non_inv;
                end
                WK_PHASE: begin
                    if (hit)                     pin_nx = step_up ? !non_inv : non_inv;
                    else if (special && at_top)  pin_nx = non_inv;
                end
                default: begin
                    if (hit) pin_nx = !non_inv;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      pin_q <= 1'b0;
        else if (adv) pin_q <= pin_nx;
    end

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              gpio_in,
    output logic              pwm_out,
    output logic              ovf_flag,
    output logic [W-1:0]      count_out
);

    localparam logic [W-1:0] MAXV = '1;

    logic [2:0]   mode;
    logic [1:0]   com;
    logic [W-1:0] eff_a, eff_b, top, cnt;
    wave_cfg_t    cfg;
    wave_kind_e   kind;
    logic         immediate, load_evt, cnt_wr;
    logic         adv, at_top, step_up, ovf_evt, pin_q;

    assign cfg       = decode_mode(mode);
    assign kind      = cfg.kind;
    assign top       = cfg.top_from_a ? eff_a : MAXV;
    assign immediate = is_immediate(kind);
    assign cnt_wr    = wr_en && (wr_addr == ADDR_COUNT);
    assign load_evt  = adv && at_top && !immediate;

    pwm8_regs #(.W(W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .cnt       (cnt),
        .immediate (immediate),
        .load_evt  (load_evt),
        .ovf_evt   (ovf_evt),
        .mode      (mode),
        .com       (com),
        .eff_a     (eff_a),
        .eff_b     (eff_b),
        .ovf_flag  (ovf_flag),
        .rd_data   (rd_data)
    );

    pwm8_counter #(.W(W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (wr_data),
        .kind     (kind),
        .top      (top),
        .cnt      (cnt),
        .adv      (adv),
        .at_top   (at_top),
        .step_up  (step_up),
        .ovf_evt  (ovf_evt)
    );

    pwm8_wave #(.W(W)) wave_i (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .kind    (kind),
        .com     (com),
        .cnt     (cnt),
        .cmp     (eff_b),
        .top     (top),
        .at_top  (at_top),
        .step_up (step_up),
        .pin_q   (pin_q)
    );

    assign pwm_out   = com[1] ? pin_q : gpio_in;
    assign count_out = cnt;

endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      count_out,
    input logic              ovf_flag,
    input logic              pwm_out,
    input wave_kind_e        kind,
    input logic              at_top,
    input logic [1:0]        com,
    input logic              ovf_evt
);

    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr == ADDR_COUNT);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(count_out));

    assert_norm_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && kind == WK_NORMAL) |=> (count_out == $past(count_out) + 1'b1));

    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(wr_en && wr_addr == ADDR_FLAG && wr_data[0])) |=> ovf_flag);

    assert_fast_top_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && kind == WK_FAST && at_top && com == 2'b10
         && !(wr_en && wr_addr == ADDR_CTRL)) |=> pwm_out);

endmodule

bind pwm8_timer pwm8_timer_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_out (count_out),
    .ovf_flag  (ovf_flag),
    .pwm_out   (pwm_out),
    .kind      (kind),
    .at_top    (at_top),
    .com       (com),
    .ovf_evt   (ovf_evt)
);

// File: tb/pwm8_timer_tb_top.sv
module pwm8_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic       gpio_in = 1'b1;
    logic [7:0] rd_data;
    logic       pwm_out;
    logic       ovf_flag;
    logic [7:0] count_out;

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;

    // bench model state
    logic [7:0] m_cnt, m_ba, m_bb, m_ea, m_eb;
    logic [2:0] m_mode;
    logic [1:0] m_com;
    logic       m_up, m_pin, m_ovf;

    always #5 clk = ~clk;

    pwm8_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .gpio_in(gpio_in), .pwm_out(pwm_out), .ovf_flag(ovf_flag),
        .count_out(count_out)
    );

    // 0 normal, 1 restart, 2 single-slope, 3 dual-slope
    function automatic int kind_of(input logic [2:0] m);
        case (m)
            3'd1, 3'd5: return 3;
            3'd2:       return 1;
            3'd3, 3'd7: return 2;
            default:    return 0;
        endcase
    endfunction

    function automatic logic topa_of(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int k;
        logic [7:0] top, ncnt, nba, nbb, nea, neb;
        logic attop, stepup, cw, adv, ovfe, nup, npin, hit, spec, ni, novf;
        logic [2:0] nmode;
        logic [1:0] ncom;
        k = kind_of(m_mode);
        top = topa_of(m_mode) ? m_ea : 8'hFF;
        cw = wr_en && (wr_addr == 3'd3);
        adv = tick && !cw;
        attop = (k == 3) ? (m_up && (m_cnt >= top)) : (m_cnt == top);
        stepup = m_up ? !attop : (m_cnt == 8'h00);
        ncnt = m_cnt;
        nup = (k == 3) ? m_up : 1'b1;
        if (cw) ncnt = wr_data;
        else if (adv) begin
            if (k == 3) begin
                if (m_up) begin
                    if (attop) begin ncnt = (m_cnt == 0) ? 8'h00 : m_cnt - 8'd1; nup = 1'b0; end
                    else ncnt = m_cnt + 8'd1;
                end else begin
                    if (m_cnt == 0) begin ncnt = (top == 0) ? 8'h00 : 8'h01; nup = 1'b1; end
                    else ncnt = m_cnt - 8'd1;
                end
            end else begin
                ncnt = attop ? 8'h00 : m_cnt + 8'd1;
            end
        end
        // overflow event points (R5)
        ovfe = adv && ((k == 3) ? (m_cnt == 0) : (k == 2) ? (m_cnt == top) : (m_cnt == 8'hFF));
        novf = m_ovf;
        if (ovfe) novf = 1'b1;
        else if (wr_en && wr_addr == 3'd4 && wr_data[0]) novf = 1'b0;
        // pin actions (R8..R11)
        spec = m_com[1] && (m_eb == top);
        hit = (m_cnt == m_eb) && !spec;
        ni = (m_com == 2'b10);
        npin = m_pin;
        if (adv && m_com[1]) begin
            if (k == 2) begin
                if (attop) npin = ni; else if (hit) npin = !ni;
            end else if (k == 3) begin
                if (hit) npin = stepup ? !ni : ni;
                else if (spec && attop) npin = ni;
            end else if (hit) npin = !ni;
        end
        // registers and compare buffering (R4)
        nmode = m_mode; ncom = m_com;
        if (wr_en && wr_addr == 3'd0) begin nmode = wr_data[2:0]; ncom = wr_data[5:4]; end
        nba = (wr_en && wr_addr == 3'd1) ? wr_data : m_ba;
        nbb = (wr_en && wr_addr == 3'd2) ? wr_data : m_bb;
        nea = m_ea; neb = m_eb;
        if (k <= 1) begin nea = nba; neb = nbb; end
        else if (adv && attop) begin nea = m_ba; neb = m_bb; end
        m_cnt = ncnt; m_up = nup; m_ovf = novf; m_pin = npin;
        m_mode = nmode; m_com = ncom; m_ba = nba; m_bb = nbb; m_ea = nea; m_eb = neb;
    endtask

    function automatic logic [7:0] rd_exp();
        case (rd_addr)
            3'd0: return {2'b00, m_com, 1'b0, m_mode};
            3'd1: return m_ba;
            3'd2: return m_bb;
            3'd3: return m_cnt;
            3'd4: return {7'b0, m_ovf};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string pwm_tag();
        int k;
        k = kind_of(m_mode);
        if (!m_com[1]) return "R7";
        if (m_eb == (topa_of(m_mode) ? m_ea : 8'hFF)) return "R10";
        if (k == 2) return "R8";
        if (k == 3) return "R9";
        return "R11";
    endfunction

    task automatic compare_all();
        check("R3", "count", count_out, m_cnt);
        check("R5", "overflow flag", {7'b0, ovf_flag}, {7'b0, m_ovf});
        check(pwm_tag(), "pwm_out", {7'b0, pwm_out}, {7'b0, (m_com[1] ? m_pin : gpio_in)});
        check("R12", "rd_data", rd_data, rd_exp());
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ba = 0; m_bb = 0; m_ea = 0; m_eb = 0;
            m_mode = 0; m_com = 0; m_up = 1; m_pin = 0; m_ovf = 0;
        end else begin
            model_step();
        end
        #2;
        if (chk_on) compare_all();
    end

    task automatic drive(input logic t, input logic we, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 8'h00);
    endtask

    function automatic logic [7:0] rnd_data();
        case ($urandom_range(0, 7))
            0: return 8'hFF;
            1: return 8'h00;
            2: return 8'($urandom_range(1, 6));
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        repeat (3) drive(1'b0, 1'b0, 3'd0, 8'h00);
        rst = 1'b0;
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        // R1: reset state
        check("R1", "count after reset", count_out, 8'h00);
        check("R1", "flag after reset", {7'b0, ovf_flag}, 8'h00);
        check("R1", "pin follows gpio", {7'b0, pwm_out}, 8'h01);
        check("R1", "ctrl after reset", rd_data, 8'h00);
        chk_on = 1'b1;

        // R12: reserved control bits read zero
        drive(1'b0, 1'b1, 3'd0, 8'hFF);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R12", "ctrl readback", rd_data, 8'h37);
        drive(1'b0, 1'b1, 3'd0, 8'h00);

        // R2: count write with tick wins; no tick keeps count
        drive(1'b1, 1'b1, 3'd3, 8'h10);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R2", "count load over tick", count_out, 8'h10);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R2", "count holds without tick", count_out, 8'h10);

        // R6: overflow set and clearing write in the same cycle
        drive(1'b0, 1'b1, 3'd3, 8'hFE);
        drive(1'b1, 1'b0, 3'd0, 8'h00);
        drive(1'b1, 1'b1, 3'd4, 8'h01);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R6", "set wins over clear", {7'b0, ovf_flag}, 8'h01);
        check("R3", "normal wrap to 0", count_out, 8'h00);
        drive(1'b0, 1'b1, 3'd4, 8'h01);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R6", "write-1 clears flag", {7'b0, ovf_flag}, 8'h00);

        // R4: buffered ceiling in code 7
        drive(1'b0, 1'b1, 3'd1, 8'd20);
        drive(1'b0, 1'b1, 3'd3, 8'd5);
        drive(1'b0, 1'b1, 3'd0, 8'h07);
        drive(1'b0, 1'b1, 3'd1, 8'd10);
        ticks(15);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R4", "old ceiling still in force", count_out, 8'd20);
        ticks(12);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R4", "new ceiling after period", count_out, 8'd0);

        // R10: compare B equal to TOP in code 3, action 10
        drive(1'b0, 1'b1, 3'd0, 8'h23);
        drive(1'b0, 1'b1, 3'd2, 8'hFF);
        ticks(600);
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        check("R10", "output stays high", {7'b0, pwm_out}, 8'h01);

        // random traffic across all codes (R7, R9, R11 judged by model)
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            tick = ($urandom_range(0, 3) != 0);
            wr_en = ($urandom_range(0, 11) == 0);
            wr_addr = 3'($urandom_range(0, 5));
            wr_data = rnd_data();
            rd_addr = 3'($urandom_range(0, 7));
            gpio_in = 1'($urandom_range(0, 1));
        end
        drive(1'b0, 1'b0, 3'd0, 8'h00);
        drive(1'b0, 1'b0, 3'd0, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule